// File: doc/BRIEF.md
# PCIe Error Status and Reporting Unit

This block gathers single-cycle error event pulses raised by the physical, data link and transaction layers of a PCI Express port, plus four device-specific fault sources. Each event sets a sticky bit in one of three status registers: correctable, uncorrectable and device-specific. A per-bit mask decides whether the event is reported. A severity register sorts reportable uncorrectable events into fatal and nonfatal. A device control register decides which upstream message requests may leave the block.

Reported events produce a one-cycle message request pulse (correctable, nonfatal or fatal). They also set detected bits in a device status register and raise bits in an interrupt status register, which feed a single masked interrupt output. When a malformed packet is reported, its header is locked into a log register. The log stays locked until software acknowledges the malformed-packet status bit.

Software reaches every register through a plain single-cycle write strobe with a combinational read port. Status registers clear when a 1 is written to a bit. There is no streaming data path: the events, header and message pulses are plain control pins with no back-pressure. A consumer of the message pulses must take each pulse in the cycle it appears.

Top module: `pcie_err_report`

## Requirements
- R1: Correctable events map as cor_ev[0] receiver error to bit 0, cor_ev[1] bad TLP to bit 6, cor_ev[2] bad DLLP to bit 7, cor_ev[3] replay counter rollover to bit 8 and cor_ev[4] replay timer timeout to bit 12 of the correctable status register (address 0). Its mask register is at address 1.
- R2: Uncorrectable events map as unc_ev[0] link training error to bit 0, unc_ev[1] data link protocol error to bit 4 and unc_ev[2] malformed TLP to bit 18 of the uncorrectable status register (address 2). Its mask is at address 3 and its severity register at address 4.
- R3: Device-specific events map as dev_ev[0] outbound header parity error to bit 28, dev_ev[1] poisoned TLP transmitted to bit 29, dev_ev[2] completion received with CA status to bit 30 and dev_ev[3] completion received with UR status to bit 31 of the device-specific status register (address 5). Its mask is at address 6. These events never produce a message pulse and never set a device status detected bit.
- R4: Status bits are sticky and clear only when a 1 is written to them. A set and a clear of the same bit in the same cycle leaves the bit set. Unimplemented bits of every status, mask and severity register read 0.
- R5: A masked event still sets its status bit. It produces no message pulse, no device status detected bit and no interrupt status bit.
- R6: An unmasked correctable event sets device status detected bit 0 (address 10, write-1-to-clear) in the next cycle. If device control bit 0 (address 9) is 1, it also pulses msg_cor for one cycle in that same next cycle.
- R7: An unmasked uncorrectable event whose severity bit is 1 sets detected bit 2 and, if device control bit 2 is 1, pulses msg_fatal. One whose severity bit is 0 sets detected bit 1 and, if device control bit 1 is 1, pulses msg_nonfatal. The pulse and the detected bit appear in the next cycle.
- R8: In any cycle at most one message pulse is high. When several classes are raised together, fatal wins over nonfatal and nonfatal wins over correctable. The losing classes are dropped.
- R9: The interrupt status register (address 7, write-1-to-clear) sets bit 9 on any unmasked correctable event and bit 8 on any unmasked uncorrectable event. It sets bit 10 on any unmasked device-specific, data link protocol or malformed TLP event. The interrupt mask register (address 8) bits 10:8 gate those bits. irq is high while any unmasked interrupt status bit is set.
- R10: A malformed TLP event captures hdr_in into the header log (address 11) and sets the valid flag (address 12, bit 0), but only when no logged header is pending. Clearing status bit 18 clears the valid flag. While the flag is set, the log holds its value.
- R11: After reset every register reads 0 except severity, which reads 0x00000011 (training and data link protocol errors fatal). All outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cor_ev | input | 5 | Correctable error event pulses |
| unc_ev | input | 3 | Uncorrectable error event pulses |
| dev_ev | input | 4 | Device-specific error event pulses |
| hdr_in | input | HDR_W | Header of the packet flagged by unc_ev[2] |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| msg_cor | output | 1 | Correctable message request pulse |
| msg_nonfatal | output | 1 | Nonfatal message request pulse |
| msg_fatal | output | 1 | Fatal message request pulse |
| irq | output | 1 | Summary interrupt |

## Verification
Each event source is swept alone under both mask settings, and each uncorrectable source also under both severity settings. This separates a wrong bit position, a mask that fails to block, and a severity decode that picks the wrong class or the wrong detected bit. All eight combinations of simultaneous correctable, nonfatal and fatal raises show whether the priority order and the one-pulse rule hold. Further directed patterns cover a set and clear of the same bit in one cycle, control-register gating with the detected bit still set, interrupt masking with status retained, and a repeated malformed packet that must not overwrite a pending header.

// File: rtl/pcie_err_pkg.sv
package pcie_err_pkg;
  localparam int REG_W = 32;
  localparam int NCOR  = 5;
  localparam int NUNC  = 3;
  localparam int NDEV  = 4;
  localparam int DEV_BASE = 28;

  typedef enum logic [3:0] {
    A_COR_STS = 4'd0,  A_COR_MSK = 4'd1,  A_UNC_STS = 4'd2,  A_UNC_MSK = 4'd3,
    A_UNC_SEV = 4'd4,  A_DEV_STS = 4'd5,  A_DEV_MSK = 4'd6,  A_IRQ_STS = 4'd7,
    A_IRQ_MSK = 4'd8,  A_DCTL    = 4'd9,  A_DDET    = 4'd10, A_HLOG    = 4'd11,
    A_HVLD    = 4'd12
  } reg_addr_e;

  function automatic int cor_pos(input int i);
    case (i)
      0: return 0;
      1: return 6;
      2: return 7;
      3: return 8;
      default: return 12;
    endcase
  endfunction

  function automatic int unc_pos(input int i);
    case (i)
      0: return 0;
      1: return 4;
      default: return 18;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] cor_spread(input logic [NCOR-1:0] ev);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < NCOR; i++) r[cor_pos(i)] = ev[i];
    return r;
  endfunction

  function automatic logic [NCOR-1:0] cor_gather(input logic [REG_W-1:0] v);
    logic [NCOR-1:0] r;
    for (int i = 0; i < NCOR; i++) r[i] = v[cor_pos(i)];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] unc_spread(input logic [NUNC-1:0] ev);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUNC; i++) r[unc_pos(i)] = ev[i];
    return r;
  endfunction

  function automatic logic [NUNC-1:0] unc_gather(input logic [REG_W-1:0] v);
    logic [NUNC-1:0] r;
    for (int i = 0; i < NUNC; i++) r[i] = v[unc_pos(i)];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] dev_spread(input logic [NDEV-1:0] ev);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < NDEV; i++) r[DEV_BASE+i] = ev[i];
    return r;
  endfunction

  function automatic logic [NDEV-1:0] dev_gather(input logic [REG_W-1:0] v);
    logic [NDEV-1:0] r;
    for (int i = 0; i < NDEV; i++) r[i] = v[DEV_BASE+i];
    return r;
  endfunction

  localparam logic [REG_W-1:0] COR_IMPL  = cor_spread('1);
  localparam logic [REG_W-1:0] UNC_IMPL  = unc_spread('1);
  localparam logic [REG_W-1:0] DEV_IMPL  = dev_spread('1);
  localparam logic [REG_W-1:0] IRQ_IMPL  = 32'h0000_0700;
  localparam logic [REG_W-1:0] DCTL_IMPL = 32'h0000_0007;
  localparam logic [REG_W-1:0] SEV_RST   = unc_spread(3'b011);
endpackage

// File: rtl/err_w1c_reg.sv
module err_w1c_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] clr_m;

  assign clr_m = clr_en_i ? clr_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= ((q_o & ~clr_m) | set_i) & IMPL;
  end

  // R4: without a clear write no set bit may drop
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en_i |=> (($past(q_o) & ~q_o) == '0));
  // R4: a set request wins over a clear in the same cycle
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & IMPL) != '0) |=> ((q_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));
endmodule

// File: rtl/err_msg_pick.sv
module err_msg_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic cor_i,
  input  logic nf_i,
  input  logic fat_i,
  output logic cor_o,
  output logic nf_o,
  output logic fat_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cor_o <= 1'b0;
      nf_o  <= 1'b0;
      fat_o <= 1'b0;
    end else begin
      fat_o <= fat_i;
      nf_o  <= nf_i & ~fat_i;
      cor_o <= cor_i & ~nf_i & ~fat_i;
    end
  end

  assert_one_msg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cor_o, nf_o, fat_o}));
  assert_fatal_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fat_i |=> fat_o);
  assert_nf_over_cor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_i && !fat_i) |=> (nf_o && !cor_o));
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cor_i |=> !cor_o);
endmodule

// File: rtl/err_hdr_log.sv
module err_hdr_log #(
  parameter int HDR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             rel_i,
  output logic [HDR_W-1:0] hdr_o,
  output logic             vld_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_o <= '0;
      vld_o <= 1'b0;
    end else if (cap_i && (!vld_o || rel_i)) begin
      hdr_o <= hdr_i;
      vld_o <= 1'b1;
    end else if (rel_i) begin
      vld_o <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !rel_i) |=> (vld_o && $stable(hdr_o)));
  assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && !vld_o) |=> (vld_o && hdr_o == $past(hdr_i)));
endmodule

// File: rtl/pcie_err_report.sv
module pcie_err_report
  import pcie_err_pkg::*;
#(
  parameter int HDR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       cor_ev,
  input  logic [2:0]       unc_ev,
  input  logic [3:0]       dev_ev,
  input  logic [HDR_W-1:0] hdr_in,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             msg_cor,
  output logic             msg_nonfatal,
  output logic             msg_fatal,
  output logic             irq
);
  logic [REG_W-1:0] cor_msk, unc_msk, dev_msk, unc_sev, irq_msk, dctl;
  logic [REG_W-1:0] cor_sts, unc_sts, dev_sts, irq_sts, ddet;
  logic [NCOR-1:0]  cor_unm;
  logic [NUNC-1:0]  unc_unm, sev_g;
  logic             cor_any, nf_any, fat_any, dev_any;
  logic [REG_W-1:0] irq_set, det_set;
  logic [HDR_W-1:0] hlog;
  logic             hvld;

  // reporting decisions
  assign cor_unm = cor_ev & ~cor_gather(cor_msk);
  assign unc_unm = unc_ev & ~unc_gather(unc_msk);
  assign sev_g   = unc_gather(unc_sev);
  assign cor_any = |cor_unm;
  assign fat_any = |(unc_unm & sev_g);
  assign nf_any  = |(unc_unm & ~sev_g);
  assign dev_any = |(dev_ev & ~dev_gather(dev_msk));
  assign det_set = {29'd0, fat_any, nf_any, cor_any};
  assign irq_set = {21'd0, dev_any | unc_unm[1] | unc_unm[2], cor_any, |unc_unm, 8'd0};

  // software-owned control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cor_msk <= '0;
      unc_msk <= '0;
      dev_msk <= '0;
      unc_sev <= SEV_RST;
      irq_msk <= '0;
      dctl    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_COR_MSK: cor_msk <= reg_wdata & COR_IMPL;
        A_UNC_MSK: unc_msk <= reg_wdata & UNC_IMPL;
        A_UNC_SEV: unc_sev <= reg_wdata & UNC_IMPL;
        A_DEV_MSK: dev_msk <= reg_wdata & DEV_IMPL;
        A_IRQ_MSK: irq_msk <= reg_wdata & IRQ_IMPL;
        A_DCTL:    dctl    <= reg_wdata & DCTL_IMPL;
        default: ;
      endcase
    end
  end

  // sticky status registers
  err_w1c_reg #(.W(REG_W), .IMPL(COR_IMPL)) u_cor_sts (
    .clk, .rst_n, .set_i(cor_spread(cor_ev)),
    .clr_en_i(reg_wr && reg_addr == A_COR_STS), .clr_i(reg_wdata), .q_o(cor_sts));
  err_w1c_reg #(.W(REG_W), .IMPL(UNC_IMPL)) u_unc_sts (
    .clk, .rst_n, .set_i(unc_spread(unc_ev)),
    .clr_en_i(reg_wr && reg_addr == A_UNC_STS), .clr_i(reg_wdata), .q_o(unc_sts));
  err_w1c_reg #(.W(REG_W), .IMPL(DEV_IMPL)) u_dev_sts (
    .clk, .rst_n, .set_i(dev_spread(dev_ev)),
    .clr_en_i(reg_wr && reg_addr == A_DEV_STS), .clr_i(reg_wdata), .q_o(dev_sts));
  err_w1c_reg #(.W(REG_W), .IMPL(IRQ_IMPL)) u_irq_sts (
    .clk, .rst_n, .set_i(irq_set),
    .clr_en_i(reg_wr && reg_addr == A_IRQ_STS), .clr_i(reg_wdata), .q_o(irq_sts));
  err_w1c_reg #(.W(REG_W), .IMPL(DCTL_IMPL)) u_ddet (
    .clk, .rst_n, .set_i(det_set),
    .clr_en_i(reg_wr && reg_addr == A_DDET), .clr_i(reg_wdata), .q_o(ddet));

  // upstream message requests
  err_msg_pick u_pick (
    .clk, .rst_n,
    .cor_i(cor_any & dctl[0]), .nf_i(nf_any & dctl[1]), .fat_i(fat_any & dctl[2]),
    .cor_o(msg_cor), .nf_o(msg_nonfatal), .fat_o(msg_fatal));

  // header log, released by acknowledging the malformed-packet status bit
  err_hdr_log #(.HDR_W(HDR_W)) u_hlog (
    .clk, .rst_n, .cap_i(unc_ev[2]), .hdr_i(hdr_in),
    .rel_i(reg_wr && reg_addr == A_UNC_STS && reg_wdata[unc_pos(2)]),
    .hdr_o(hlog), .vld_o(hvld));

  assign irq = |(irq_sts[10:8] & ~irq_msk[10:8]);

  always_comb begin
    case (reg_addr)
      A_COR_STS: reg_rdata = cor_sts;
      A_COR_MSK: reg_rdata = cor_msk;
      A_UNC_STS: reg_rdata = unc_sts;
      A_UNC_MSK: reg_rdata = unc_msk;
      A_UNC_SEV: reg_rdata = unc_sev;
      A_DEV_STS: reg_rdata = dev_sts;
      A_DEV_MSK: reg_rdata = dev_msk;
      A_IRQ_STS: reg_rdata = irq_sts;
      A_IRQ_MSK: reg_rdata = irq_msk;
      A_DCTL:    reg_rdata = dctl;
      A_DDET:    reg_rdata = ddet;
      A_HLOG:    reg_rdata = REG_W'(hlog);
      A_HVLD:    reg_rdata = {31'd0, hvld};
      default:   reg_rdata = '0;
    endcase
  end

  // R3: device-specific events alone never request a message
  assert_dev_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_ev == '0 && unc_ev == '0) |=> !(msg_cor || msg_nonfatal || msg_fatal));
  // R5: fully masked correctable events leave the detected bit untouched
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_unm == '0 && !(reg_wr && reg_addr == A_DDET)) |=> (ddet[0] == $past(ddet[0])));
  // R9: summary interrupt follows unmasked interrupt status
  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sts[9] && !irq_msk[9]) |-> irq);
endmodule

// File: tb/pcie_err_report_bench.sv
`timescale 1ns/100ps
module pcie_err_report_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cor_ev = '0;
  logic [2:0]  unc_ev = '0;
  logic [3:0]  dev_ev = '0;
  logic [31:0] hdr_in = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_cor, msg_nonfatal, msg_fatal, irq;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [2:0] mv;   // {fatal, nonfatal, cor} sampled after a pulse
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  pcie_err_report u_pcie_err_report (.*);

  function automatic int cp(input int i);
    case (i) 0: return 0; 1: return 6; 2: return 7; 3: return 8; default: return 12; endcase
  endfunction
  function automatic int up(input int i);
    case (i) 0: return 0; 1: return 4; default: return 18; endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [4:0] c, input logic [2:0] u, input logic [3:0] dv,
                       input logic [31:0] h);
    @(negedge clk); cor_ev = c; unc_ev = u; dev_ev = dv; hdr_in = h;
    @(negedge clk); cor_ev = '0; unc_ev = '0; dev_ev = '0;
    mv = {msg_fatal, msg_nonfatal, msg_cor};
  endtask

  task automatic clear_all();
    wr(4'd0, '1); wr(4'd2, '1); wr(4'd5, '1); wr(4'd7, '1); wr(4'd10, '1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    for (int a = 0; a <= 12; a++) begin
      rd(4'(a), rv);
      chk($sformatf("R11 reset addr %0d", a), rv, (a == 4) ? 32'h11 : 32'h0);
    end
    chk("R11 reset outputs", {28'd0, msg_fatal, msg_nonfatal, msg_cor, irq}, 32'h0);

    wr(4'd9, 32'h7);
    // R1 R5 R6 R9 correctable sweep
    for (int i = 0; i < 5; i++) begin
      for (int m = 0; m < 2; m++) begin
        wr(4'd1, m ? (32'h1 << cp(i)) : 32'h0);
        pulse(5'(1 << i), 3'd0, 4'd0, 32'd0);
        chk($sformatf("R6 msg cor src%0d mask%0d", i, m), {29'd0, mv}, m ? 32'h0 : 32'h1);
        rd(4'd0, rv); chk($sformatf("R1 cor status src%0d", i), rv, 32'h1 << cp(i));
        rd(4'd10, rv); chk($sformatf("R5 detected cor src%0d mask%0d", i, m), rv, m ? 32'h0 : 32'h1);
        rd(4'd7, rv); chk($sformatf("R9 irq sts cor src%0d mask%0d", i, m), rv, m ? 32'h0 : 32'h200);
        chk("R9 irq pin cor", {31'd0, irq}, m ? 32'h0 : 32'h1);
        clear_all();
      end
    end
    wr(4'd1, 32'h0);

    // R2 R7 R5 R9 uncorrectable sweep over severity and mask
    for (int i = 0; i < 3; i++) begin
      for (int s = 0; s < 2; s++) begin
        for (int m = 0; m < 2; m++) begin
          wr(4'd4, s ? (32'h1 << up(i)) : 32'h0);
          wr(4'd3, m ? (32'h1 << up(i)) : 32'h0);
          pulse(5'd0, 3'(1 << i), 4'd0, 32'd0);
          chk($sformatf("R7 msg unc src%0d sev%0d mask%0d", i, s, m), {29'd0, mv},
              m ? 32'h0 : (s ? 32'h4 : 32'h2));
          rd(4'd2, rv); chk($sformatf("R2 unc status src%0d", i), rv, 32'h1 << up(i));
          rd(4'd10, rv); chk($sformatf("R7 detected unc src%0d sev%0d mask%0d", i, s, m), rv,
              m ? 32'h0 : (s ? 32'h4 : 32'h2));
          rd(4'd7, rv); chk($sformatf("R9 irq sts unc src%0d mask%0d", i, m), rv,
              m ? 32'h0 : (32'h100 | ((i != 0) ? 32'h400 : 32'h0)));
          clear_all();
        end
      end
    end
    wr(4'd3, 32'h0);

    // R3 R5 R9 device-specific sweep
    for (int i = 0; i < 4; i++) begin
      for (int m = 0; m < 2; m++) begin
        wr(4'd6, m ? (32'h1 << (28 + i)) : 32'h0);
        pulse(5'd0, 3'd0, 4'(1 << i), 32'd0);
        chk($sformatf("R3 no msg dev src%0d", i), {29'd0, mv}, 32'h0);
        rd(4'd5, rv); chk($sformatf("R3 dev status src%0d", i), rv, 32'h1 << (28 + i));
        rd(4'd10, rv); chk("R3 no detected dev", rv, 32'h0);
        rd(4'd7, rv); chk($sformatf("R9 irq sts dev src%0d mask%0d", i, m), rv, m ? 32'h0 : 32'h400);
        clear_all();
      end
    end
    wr(4'd6, 32'h0);

    // R8 priority: training fatal, data link protocol nonfatal
    wr(4'd4, 32'h1);
    for (int c = 0; c < 8; c++) begin
      pulse(5'(c & 1), {1'b0, c[1], c[2]}, 4'd0, 32'd0);
      chk($sformatf("R8 priority combo %0d", c), {29'd0, mv},
          c[2] ? 32'h4 : (c[1] ? 32'h2 : (c[0] ? 32'h1 : 32'h0)));
      @(negedge clk);
      chk("R8 single-cycle pulse", {29'd0, msg_fatal, msg_nonfatal, msg_cor}, 32'h0);
      clear_all();
    end

    // R6 R7 control gating keeps detected bits
    wr(4'd9, 32'h0);
    pulse(5'd1, 3'd0, 4'd0, 32'd0);
    chk("R6 gated cor no msg", {29'd0, mv}, 32'h0);
    pulse(5'd0, 3'd1, 4'd0, 32'd0);
    chk("R7 gated fatal no msg", {29'd0, mv}, 32'h0);
    rd(4'd10, rv); chk("R7 detected with control off", rv, 32'h5);
    clear_all();
    wr(4'd9, 32'h7);

    // R4 sticky, set wins over clear, unimplemented bits
    pulse(5'd1, 3'd0, 4'd0, 32'd0);
    @(negedge clk); cor_ev = 5'd1; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h1;
    @(negedge clk); cor_ev = '0; reg_wr = 1'b0;
    rd(4'd0, rv); chk("R4 set wins over clear", rv, 32'h1);
    wr(4'd0, 32'h1);
    rd(4'd0, rv); chk("R4 clear by write 1", rv, 32'h0);
    wr(4'd1, '1);
    rd(4'd1, rv); chk("R4 mask implemented bits", rv, 32'h0000_11C1);
    wr(4'd1, 32'h0);
    clear_all();

    // R9 interrupt mask
    pulse(5'd2, 3'd0, 4'd0, 32'd0);
    chk("R9 irq raised", {31'd0, irq}, 32'h1);
    wr(4'd8, 32'h200);
    chk("R9 irq masked", {31'd0, irq}, 32'h0);
    rd(4'd7, rv); chk("R9 status kept when masked", rv, 32'h200);
    wr(4'd8, 32'h0);
    clear_all();

    // R10 header log
    pulse(5'd0, 3'd4, 4'd0, 32'hA5A5_0001);
    rd(4'd11, rv); chk("R10 first header", rv, 32'hA5A5_0001);
    rd(4'd12, rv); chk("R10 valid set", rv, 32'h1);
    pulse(5'd0, 3'd4, 4'd0, 32'hB0B0_0002);
    rd(4'd11, rv); chk("R10 pending header kept", rv, 32'hA5A5_0001);
    wr(4'd2, 32'h1 << 18);
    rd(4'd12, rv); chk("R10 valid cleared", rv, 32'h0);
    pulse(5'd0, 3'd1, 4'd0, 32'hDDDD_0004);
    rd(4'd11, rv); chk("R10 non-malformed ignored", rv, 32'hA5A5_0001);
    pulse(5'd0, 3'd4, 4'd0, 32'hC3C3_0003);
    rd(4'd11, rv); chk("R10 recapture", rv, 32'hC3C3_0003);
    rd(4'd12, rv); chk("R10 valid again", rv, 32'h1);
    clear_all();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule